// File: doc/BRIEF.md
# Accumulator SPI Clock Generator

This block derives a serial clock for an SPI engine from a fast reference clock. A 16-bit frequency word is added to a phase accumulator on every reference cycle. Each time the accumulator passes half of a 2048-unit output period, the serial clock changes level. The output rate is therefore close to reference × word / 2048, with fractional rates supported. An optional loop-clear mode drops the remainder at each wrap, which gives an exactly repeating half period. A double-rate select doubles the step.

The generator also marks, one reference cycle wide, the serial-clock edges on which the data path should drive new data (launch) and capture incoming data (sample). Each strobe can be tied to the rising or the falling edge. A polarity setting fixes the level the clock rests at when idle.

A registered flag tells the receive side to use an asynchronous input path once the programmed rate exceeds a threshold frequency, which defaults to 30 MHz. Dropping the enable stops the clock cleanly at its idle level and clears the accumulator.

Top module: `acc_sclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the serial clock, both strobes and the asynchronous-path flag are 0.
- R2: While enabled, the accumulator gains the step on every reference cycle. The serial clock changes level in the cycle after the sum reaches 1024, and the excess over 1024 is kept. Over 2048 enabled cycles with a word of 64, starting from idle, the clock changes level exactly 128 times.
- R3: With loop-clear set, the accumulator restarts from 0 at each wrap. With a word of 300, every half period is exactly 4 cycles long.
- R4: With double-rate select set, the step is twice the frequency word.
- R5: A step of 1024 or more is limited to 1024, so the serial clock changes level on every enabled cycle.
- R6: A step of 0 leaves the serial clock unchanged and produces no strobes.
- R7: The idle level equals the polarity input (1 = rest high). The polarity input is taken only while disabled at the idle level, and changes made while the clock runs have no effect.
- R8: The launch strobe is 1 for exactly the cycle in which the serial clock output shows a new level. It fires on rising edges when launch-rising is 1 and on falling edges when it is 0.
- R9: The sample strobe follows the same rule, with the sample-rising input choosing the edge.
- R10: If the enable drops while the clock is at its idle level, the clock stops at once. Otherwise the current half period runs to its end, and the clock stops at the idle level. In both cases the accumulator clears, and no strobes occur while stopped.
- R11: The asynchronous-path flag is registered. It is 1 when the limited step exceeds floor(ASYNC_HZ × 2048 / REF_HZ), which is 307 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the serial clock |
| freq_word_i | input | 16 | Frequency word, added per reference cycle |
| loop_clear_i | input | 1 | Clear the accumulator at each wrap |
| rate_x2_i | input | 1 | Double the step |
| launch_rise_i | input | 1 | Launch on rising (1) or falling (0) edge |
| sample_rise_i | input | 1 | Sample on rising (1) or falling (0) edge |
| idle_high_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Launch strobe, one cycle per selected edge |
| sample_o | output | 1 | Sample strobe, one cycle per selected edge |
| async_path_o | output | 1 | Select the asynchronous input path |

## Verification
The assertions check the following on every cycle:
- each strobe coincides with a level change of the serial clock in the direction its select asked for;
- a zero step never yields a strobe;
- a saturated step toggles the clock on every enabled cycle.

The remaining behaviour can only be shown by the bench's scenarios, which compare every cycle against a model built from the requirements:
- the carried remainder against the loop-cleared accumulator;
- toggle counts over long windows;
- the clean stop after a mid-phase disable;
- polarity being ignored while running;
- the exact 307/308 boundary of the asynchronous-path flag.

// File: rtl/acc_sclk_pkg.sv
package acc_sclk_pkg;

    // Strobe pair emitted together with a serial-clock edge.
    typedef struct packed {
        logic launch;
        logic sample;
    } strobe_t;

    localparam int unsigned DEF_FREQ_W   = 16;
    localparam int unsigned DEF_FULL_MOD = 2048;

endpackage

// File: rtl/acc_sclk_step.sv
// Turns the frequency word into the per-cycle accumulator step:
// optional doubling, then a limit of one half period per cycle.
module acc_sclk_step #(
    parameter int unsigned FREQ_W   = 16,
    parameter int unsigned HALF_MOD = 1024,
    parameter int unsigned INC_W    = 11
) (
    input  logic [FREQ_W-1:0] word_i,
    input  logic              x2_i,
    output logic [INC_W-1:0]  inc_o
);
    localparam int unsigned RAW_W = FREQ_W + 1;
    localparam logic [RAW_W-1:0] HALF_R = RAW_W'(HALF_MOD);

    logic [RAW_W-1:0] raw;

    assign raw = {1'b0, word_i} << x2_i;

    always_comb begin
        if (raw >= HALF_R) begin
            inc_o = INC_W'(HALF_MOD);
        end else begin
            inc_o = raw[INC_W-1:0];
        end
    end
endmodule

// File: rtl/acc_sclk_rate_det.sv
// Flags steps whose resulting serial rate exceeds the async threshold.
module acc_sclk_rate_det #(
    parameter int unsigned INC_W    = 11,
    parameter int unsigned HALF_MOD = 1024,
    parameter int unsigned LIMIT    = 307
) (
    input  logic [INC_W-1:0] inc_i,
    output logic             fast_o
);
    localparam int unsigned LIM_C = (LIMIT > HALF_MOD) ? HALF_MOD : LIMIT;
    localparam logic [INC_W:0] LIM_V = (INC_W+1)'(LIM_C);

    assign fast_o = ({1'b0, inc_i} > LIM_V);
endmodule

// File: rtl/acc_sclk_edge_sel.sv
// Chooses which serial-clock edges produce launch and sample strobes.
module acc_sclk_edge_sel (
    input  logic                    edge_i,
    input  logic                    new_lvl_i,
    input  logic                    launch_rise_i,
    input  logic                    sample_rise_i,
    output acc_sclk_pkg::strobe_t   stb_o
);
    always_comb begin
        stb_o.launch = edge_i && (new_lvl_i == launch_rise_i);
        stb_o.sample = edge_i && (new_lvl_i == sample_rise_i);
    end
endmodule

// File: rtl/acc_sclk_gen.sv
// Phase-accumulator serial clock generator with edge strobes.
module acc_sclk_gen #(
    parameter int unsigned FREQ_W   = acc_sclk_pkg::DEF_FREQ_W,
    parameter int unsigned FULL_MOD = acc_sclk_pkg::DEF_FULL_MOD,
    parameter int unsigned REF_HZ   = 200_000_000,
    parameter int unsigned ASYNC_HZ = 30_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [FREQ_W-1:0] freq_word_i,
    input  logic              loop_clear_i,
    input  logic              rate_x2_i,
    input  logic              launch_rise_i,
    input  logic              sample_rise_i,
    input  logic              idle_high_i,
    output logic              sclk_o,
    output logic              launch_o,
    output logic              sample_o,
    output logic              async_path_o
);
    localparam int unsigned HALF_MOD = FULL_MOD / 2;
    localparam int unsigned ACC_W    = $clog2(HALF_MOD);
    localparam int unsigned INC_W    = ACC_W + 1;
    localparam longint unsigned LIM_L =
        (longint'(ASYNC_HZ) * longint'(FULL_MOD)) / longint'(REF_HZ);
    localparam int unsigned ASYNC_LIMIT = int'(LIM_L);
    localparam logic [INC_W-1:0] HALF_V = INC_W'(HALF_MOD);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ph;     // 0 = idle-level phase
        logic             pol;    // captured idle level
        logic             sclk;
        logic             launch;
        logic             sample;
        logic             fast;
    } state_t;

    state_t state_q, state_d;

    logic [INC_W-1:0]      inc;
    logic                  fast;
    logic                  active;
    logic [INC_W-1:0]      sum;
    logic [ACC_W-1:0]      rem;
    logic                  wrap;
    logic                  ph_nx;
    logic                  pol_nx;
    logic                  lvl_nx;
    acc_sclk_pkg::strobe_t stb;

    acc_sclk_step #(
        .FREQ_W   (FREQ_W),
        .HALF_MOD (HALF_MOD),
        .INC_W    (INC_W)
    ) u_step (
        .word_i (freq_word_i),
        .x2_i   (rate_x2_i),
        .inc_o  (inc)
    );

    acc_sclk_rate_det #(
        .INC_W    (INC_W),
        .HALF_MOD (HALF_MOD),
        .LIMIT    (ASYNC_LIMIT)
    ) u_rate (
        .inc_i  (inc),
        .fast_o (fast)
    );

    // The clock keeps running after enable drops until it is back at idle.
    assign active = en_i | state_q.ph;
    assign sum    = INC_W'(state_q.acc) + inc;
    assign rem    = ACC_W'(sum - HALF_V);
    assign wrap   = active && (sum >= HALF_V);
    assign ph_nx  = state_q.ph ^ wrap;
    assign pol_nx = (!en_i && !state_q.ph) ? idle_high_i : state_q.pol;
    assign lvl_nx = ph_nx ^ pol_nx;

    acc_sclk_edge_sel u_edge (
        .edge_i        (wrap),
        .new_lvl_i     (lvl_nx),
        .launch_rise_i (launch_rise_i),
        .sample_rise_i (sample_rise_i),
        .stb_o         (stb)
    );

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d.acc = '0;
        end else if (wrap) begin
            state_d.acc = (loop_clear_i || !en_i) ? '0 : rem;
        end else begin
            state_d.acc = sum[ACC_W-1:0];
        end
        state_d.ph     = ph_nx;
        state_d.pol    = pol_nx;
        state_d.sclk   = lvl_nx;
        state_d.launch = stb.launch;
        state_d.sample = stb.sample;
        state_d.fast   = fast;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sclk_o       = state_q.sclk;
    assign launch_o     = state_q.launch;
    assign sample_o     = state_q.sample;
    assign async_path_o = state_q.fast;
endmodule

// File: rtl/acc_sclk_chk.sv
// Port-level checks for acc_sclk_gen, attached with bind below.
module acc_sclk_chk #(
    parameter int unsigned FREQ_W   = 16,
    parameter int unsigned HALF_MOD = 1024
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic [FREQ_W-1:0] freq_word_i,
    input logic              rate_x2_i,
    input logic              launch_rise_i,
    input logic              sample_rise_i,
    input logic              sclk_o,
    input logic              launch_o,
    input logic              sample_o
);
    localparam logic [FREQ_W:0] HALF_R = (FREQ_W+1)'(HALF_MOD);

    logic seen_q;
    logic sat_step;

    assign sat_step = (({1'b0, freq_word_i} << rate_x2_i) >= HALF_R);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    a_r8_launch_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && launch_o) |->
            (sclk_o != $past(sclk_o)) && (sclk_o == $past(launch_rise_i)));

    a_r9_sample_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && sample_o) |->
            (sclk_o != $past(sclk_o)) && (sclk_o == $past(sample_rise_i)));

    a_r6_zero_step_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(freq_word_i) == '0) |-> (!launch_o && !sample_o));

    a_r5_saturated_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(en_i) && $past(sat_step)) |-> (sclk_o != $past(sclk_o)));
endmodule

bind acc_sclk_gen acc_sclk_chk #(
    .FREQ_W   (FREQ_W),
    .HALF_MOD (FULL_MOD / 2)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .freq_word_i   (freq_word_i),
    .rate_x2_i     (rate_x2_i),
    .launch_rise_i (launch_rise_i),
    .sample_rise_i (sample_rise_i),
    .sclk_o        (sclk_o),
    .launch_o      (launch_o),
    .sample_o      (sample_o)
);

// File: tb/acc_sclk_gen_tb_top.sv
module acc_sclk_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1024;
    localparam int ALIM       = 307;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] word = '0;
    logic        lclr = 1'b0;
    logic        x2 = 1'b0;
    logic        lrise = 1'b0;
    logic        srise = 1'b1;
    logic        pol = 1'b0;
    logic        sclk, launch, sample, apath;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_sclk_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .en_i          (en),
        .freq_word_i   (word),
        .loop_clear_i  (lclr),
        .rate_x2_i     (x2),
        .launch_rise_i (lrise),
        .sample_rise_i (srise),
        .idle_high_i   (pol),
        .sclk_o        (sclk),
        .launch_o      (launch),
        .sample_o      (sample),
        .async_path_o  (apath)
    );

    typedef struct {
        logic  sc;
        logic  la;
        logic  sa;
        logic  ap;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    int    toggles = 0;
    logic  last_sclk = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // model state, built from the requirements
    int m_acc = 0;
    int m_ph  = 0;
    int m_pol = 0;

    task automatic check(input string rq, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", rq, got, exp);
        end
    endtask

    // Driver: compute the expected outputs after the next edge and queue them.
    task automatic tick();
        exp_t e;
        int inc, sum, wrap, act, lvl;
        inc = x2 ? 2 * int'(word) : int'(word);
        if (inc > HALF) inc = HALF;
        act  = (en || m_ph != 0) ? 1 : 0;
        wrap = 0;
        if (!en && m_ph == 0) m_pol = int'(pol);
        if (act == 0) begin
            m_acc = 0;
        end else begin
            sum = m_acc + inc;
            if (sum >= HALF) begin
                wrap  = 1;
                m_ph  = 1 - m_ph;
                m_acc = (lclr || !en) ? 0 : sum - HALF;
            end else begin
                m_acc = sum;
            end
        end
        lvl  = m_ph ^ m_pol;
        e.sc = lvl[0];
        e.la = (wrap != 0) && (lvl[0] == lrise);
        e.sa = (wrap != 0) && (lvl[0] == srise);
        e.ap = (inc > ALIM);
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Monitor: pop and compare just after each edge.
    always @(posedge clk) begin
        #1;
        if (sclk !== last_sclk) toggles++;
        last_sclk = sclk;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if ({sclk, launch, sample, apath} !== {e.sc, e.la, e.sa, e.ap}) begin
                n_bad++;
                $display("FAIL %s: sclk/launch/sample/async got %b%b%b%b expected %b%b%b%b",
                         e.tag, sclk, launch, sample, apath, e.sc, e.la, e.sa, e.ap);
            end
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", int'({sclk, launch, sample, apath}), 0);
        rst_n = 1'b1;
        check("R1", int'({sclk, launch, sample, apath}), 0);

        // R2: carried remainder, mode with sample on rising edge
        tag = "R2"; word = 16'd100; en = 1'b1; run(300);
        en = 1'b0; run(40);
        tag = "R2"; word = 16'd64; t0 = toggles; en = 1'b1; run(2048);
        check("R2", toggles - t0, 128);
        en = 1'b0; run(40);

        // R3: loop clear, word 300 -> half period of 4 cycles
        tag = "R3"; lclr = 1'b1; word = 16'd300; en = 1'b1; run(200);
        en = 1'b0; run(20); lclr = 1'b0;

        // R4: doubled step
        tag = "R4"; x2 = 1'b1; word = 16'd150; en = 1'b1; run(200);
        word = 16'd200; run(100);
        en = 1'b0; run(20); x2 = 1'b0;

        // R5: saturated step
        tag = "R5"; word = 16'd5000; t0 = toggles; en = 1'b1; run(64);
        check("R5", toggles - t0, 64);
        en = 1'b0; run(4);

        // R6: zero step
        tag = "R6"; word = 16'd0; en = 1'b1; run(50);
        en = 1'b0; run(4);

        // R7: idle level and polarity ignored while running
        tag = "R7"; pol = 1'b1; run(4);
        check("R7", int'(sclk), 1);
        word = 16'd128; en = 1'b1; run(20);
        pol = 1'b0; run(60);
        en = 1'b0; run(20);
        check("R7", int'(sclk), 0);

        // R8: launch on rising edge
        tag = "R8"; lrise = 1'b1; srise = 1'b0; en = 1'b1; run(100);
        en = 1'b0; run(20);
        // R9: both strobes on falling edge, inverted idle level
        tag = "R9"; lrise = 1'b0; srise = 1'b0; pol = 1'b1; run(2);
        en = 1'b1; run(100);
        en = 1'b0; run(20); pol = 1'b0; srise = 1'b1;

        // R10: stop mid-phase and at idle, then restart from a cleared accumulator
        tag = "R10"; word = 16'd100; en = 1'b1; run(14);
        en = 1'b0; run(30);
        check("R10", int'(sclk), 0);
        en = 1'b1; run(11);
        en = 1'b0; run(30);
        en = 1'b1; run(25);
        en = 1'b0; run(30);

        // R11: async path threshold
        tag = "R11"; word = 16'd307; run(5);
        check("R11", int'(apath), 0);
        word = 16'd308; run(5);
        check("R11", int'(apath), 1);
        word = 16'd154; x2 = 1'b1; run(5);
        check("R11", int'(apath), 1);
        x2 = 1'b0; word = 16'd0; run(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule